// File: doc/BRIEF.md
# Zero-Address Stack Execution Unit

This block is a small stack-machine datapath. It takes one instruction at a time over a valid/ready handshake and runs it against an internal stack of eight 16-bit registers. Two instructions carry a data-memory address: one loads a word from memory onto the stack, and the other stores the top entry to memory and removes it. The add, subtract and multiply instructions need no address. Each takes its two inputs from the top of the stack and leaves a single result there.

Data memory sits outside the block and is synchronous. A request raised in one cycle is served at the next clock edge, and read data is present in the cycle after that edge. The current top of the stack can be seen at all times. Misuse of the stack raises two sticky error flags: taking more entries than are held, or storing more than the stack can hold.

Top module: `stk_exec_unit`

## Requirements
- R1: After reset `tos_o` is 0, both error flags are 0, `instr_ready_o` is 1 and `mem_req_o` is 0.
- R2: Instruction encoding: opcode in bits [15:13] (0 load-to-stack, 1 store-from-stack, 2 add, 3 subtract, 4 multiply), memory address in bits [7:0], bits [12:8] ignored; opcodes 5 to 7 complete in one cycle with no effect on stack, flags or memory.
- R3: A load accepted with fewer than 8 entries drives `mem_req_o`=1, `mem_we_o`=0 and `mem_addr_o` equal to the address field in the accept cycle; `instr_ready_o` is 0 in the next cycle; the loaded word is on `tos_o` after the second clock edge.
- R4: A store accepted with at least one entry drives `mem_req_o`=1, `mem_we_o`=1, the address field on `mem_addr_o` and the top entry on `mem_wdata_o` in the accept cycle; `instr_ready_o` is 0 in the next cycle; the entry is removed at the second clock edge.
- R5: Add, subtract and multiply with at least two entries complete at the accept edge: both inputs are removed and the result is pushed, so depth falls by one; results wrap modulo 2^16 and the product keeps its low 16 bits.
- R6: Subtract yields the entry below the top minus the top entry.
- R7: Only the load and store instructions raise `mem_req_o`.
- R8: Arithmetic with fewer than two entries, or a store on an empty stack, sets `unf_o` (held until reset), leaves the stack unchanged, makes no memory access and takes one cycle.
- R9: A load on a full stack (8 entries) sets `ovf_o` (held until reset), is discarded without a memory access and takes one cycle.
- R10: `tos_o` shows the top entry, or 0 when the stack is empty.
- R11: The sequence load X, load Y, multiply, load W, load U, multiply, add, store Z writes (X*Y)+(W*U) to address Z and leaves the stack empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction present |
| instr_ready_o | output | 1 | Unit can accept an instruction |
| instr_i | input | 16 | Instruction word |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 8 | Word address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid the cycle after a read request |
| tos_o | output | 16 | Top-of-stack value |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |

## Verification
Subtraction is run on two unequal values, so a swapped operand order gives a different result. Addition is run with a carry out of bit 15 and multiply with a product wider than 16 bits, so missing wrap or truncation shows up. The expression sequence mixes loads and arithmetic at varying depths and stores the result, then reloads it, which tests the order of memory access and stack update across both two-cycle paths. Runs that empty the stack, fill it and exceed it, and that use the reserved opcodes, show whether the error cases leave the stack untouched, make no memory access and keep the flags set.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_ADD   = 3'd2,
    OP_SUB   = 3'd3,
    OP_MUL   = 3'd4,
    OP_RSV5  = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } stk_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_MEM  = 1'b1
  } stk_state_e;
endpackage

// File: rtl/stk_alu.sv
module stk_alu
  import stk_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  stk_op_e           op_i,
  input  logic [DATA_W-1:0] lhs_i,  // entry below top
  input  logic [DATA_W-1:0] rhs_i,  // top entry
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = lhs_i + rhs_i;
      OP_SUB:  res_o = lhs_i - rhs_i;
      OP_MUL:  res_o = lhs_i * rhs_i;  // low half kept
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/stk_regfile.sv
module stk_regfile #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic              fold_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] top_o,
  output logic [DATA_W-1:0] next_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] ent_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  widx;
  logic              wen;

  assign wen  = push_i | fold_i;
  assign widx = push_i ? cnt_q : (cnt_q - CNT_W'(2));

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          ent_q[g] <= '0;
      else if (wen && widx == CNT_W'(g))    ent_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (push_i)          cnt_q <= cnt_q + CNT_W'(1);
    else if (pop_i || fold_i) cnt_q <= cnt_q - CNT_W'(1);
  end

  assign top_o  = (cnt_q == '0) ? '0 : ent_q[IDX_W'(cnt_q - CNT_W'(1))];
  assign next_o = (cnt_q < CNT_W'(2)) ? '0 : ent_q[IDX_W'(cnt_q - CNT_W'(2))];
  assign cnt_o  = cnt_q;

  // R9
  depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  // R9
  no_push_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> cnt_q < CNT_W'(DEPTH));
  // R8
  no_pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i || fold_i) |-> cnt_q != '0);
  // R5
  one_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({push_i, pop_i, fold_i}));
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 8,
  parameter int INSTR_W = 16,
  parameter int DEPTH   = 8,
  parameter int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               instr_valid_i,
  output logic               instr_ready_o,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [DATA_W-1:0]  top_i,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  output stk_op_e            op_o,
  output logic               push_o,
  output logic               pop_o,
  output logic               fold_o,
  output logic               ovf_o,
  output logic               unf_o
);
  localparam int OP_W = 3;

  stk_state_e state_q;
  logic       pend_load_q;
  logic       ovf_q, unf_q;
  stk_op_e    op;
  logic       accept, is_arith, full, empty, has_two;
  logic       go_load, go_store, bad_unf, bad_ovf;

  assign op       = stk_op_e'(instr_i[INSTR_W-1 -: OP_W]);
  assign accept   = instr_valid_i && (state_q == ST_IDLE);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL);
  assign full     = (cnt_i == CNT_W'(DEPTH));
  assign empty    = (cnt_i == '0);
  assign has_two  = (cnt_i >= CNT_W'(2));

  assign go_load  = accept && (op == OP_LOAD) && !full;
  assign go_store = accept && (op == OP_STORE) && !empty;
  assign bad_ovf  = accept && (op == OP_LOAD) && full;
  assign bad_unf  = accept && ((is_arith && !has_two) || ((op == OP_STORE) && empty));

  if (INSTR_W - OP_W > ADDR_W) begin : g_pad
    logic pad_unused;
    assign pad_unused = ^instr_i[INSTR_W-OP_W-1:ADDR_W];
  end

  assign mem_req_o     = go_load || go_store;
  assign mem_we_o      = go_store;
  assign mem_addr_o    = instr_i[ADDR_W-1:0];
  assign mem_wdata_o   = top_i;
  assign op_o          = op;
  assign fold_o        = accept && is_arith && has_two;
  assign push_o        = (state_q == ST_MEM) && pend_load_q;
  assign pop_o         = (state_q == ST_MEM) && !pend_load_q;
  assign instr_ready_o = (state_q == ST_IDLE);
  assign ovf_o         = ovf_q;
  assign unf_o         = unf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      pend_load_q <= 1'b0;
    end else if (state_q == ST_MEM) begin
      state_q     <= ST_IDLE;
    end else if (mem_req_o) begin
      state_q     <= ST_MEM;
      pend_load_q <= go_load;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      if (bad_ovf) ovf_q <= 1'b1;
      if (bad_unf) unf_q <= 1'b1;
    end
  end

  // R3
  busy_after_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !instr_ready_o);
  // R7
  mem_only_ldst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (instr_valid_i && (op == OP_LOAD || op == OP_STORE)));
  // R8
  unf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |=> unf_o);
  // R9
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  // R4
  store_removes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |=> pop_o);
endmodule

// File: rtl/stk_exec_unit.sv
module stk_exec_unit
  import stk_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 8,
  parameter int INSTR_W = 16,
  parameter int DEPTH   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               instr_valid_i,
  output logic               instr_ready_o,
  input  logic [INSTR_W-1:0] instr_i,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  input  logic [DATA_W-1:0]  mem_rdata_i,
  output logic [DATA_W-1:0]  tos_o,
  output logic               ovf_o,
  output logic               unf_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] top, next, alu_res, wdata;
  logic [CNT_W-1:0]  cnt;
  logic              push, pop, fold;
  stk_op_e           op;

  stk_ctrl #(
    .DATA_W (DATA_W), .ADDR_W (ADDR_W), .INSTR_W(INSTR_W),
    .DEPTH  (DEPTH),  .CNT_W  (CNT_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .instr_valid_i, .instr_ready_o, .instr_i,
    .cnt_i      (cnt),
    .top_i      (top),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .op_o       (op),
    .push_o     (push),
    .pop_o      (pop),
    .fold_o     (fold),
    .ovf_o, .unf_o
  );

  stk_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i  (op),
    .lhs_i (next),
    .rhs_i (top),
    .res_o (alu_res)
  );

  assign wdata = push ? mem_rdata_i : alu_res;

  stk_regfile #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_stack (
    .clk_i, .rst_ni,
    .push_i  (push),
    .pop_i   (pop),
    .fold_i  (fold),
    .wdata_i (wdata),
    .top_o   (top),
    .next_o  (next),
    .cnt_o   (cnt)
  );

  assign tos_o = top;

  // R5
  fold_depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fold |=> cnt == $past(cnt) - CNT_W'(1));
  // R3
  load_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push |=> tos_o == $past(mem_rdata_i));
endmodule

// File: tb/stk_exec_unit_tb_top.sv
module stk_exec_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        instr_valid = 1'b0;
  logic [15:0] instr = '0;
  logic        instr_ready, mem_req, mem_we, ovf, unf;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata, mem_rdata, tos;

  logic [15:0] mem [256];
  int          stk[$];
  bit          exp_rdy = 1'b1, exp_ovf = 1'b0, exp_unf = 1'b0;
  int          total = 0, bad = 0, cycles = 0;

  always #4ns clk = ~clk;  // 125 MHz

  stk_exec_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .instr_valid_i(instr_valid), .instr_ready_o(instr_ready),
    .instr_i(instr), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .tos_o(tos), .ovf_o(ovf), .unf_o(unf)
  );

  always @(posedge clk) if (mem_req) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    else        mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_tos();
    return (stk.size() == 0) ? 16'h0 : 16'(stk[stk.size()-1]);
  endfunction

  // per-clock comparison against the model
  initial forever begin
    @(negedge clk); #2;
    if (rst_ni) begin
      chk(tos == exp_tos(), "R10 tos", tos, exp_tos());
      chk(ovf == exp_ovf, "R9 ovf", ovf, exp_ovf);
      chk(unf == exp_unf, "R8 unf", unf, exp_unf);
      chk(instr_ready == exp_rdy, "R3 ready", instr_ready, exp_rdy);
      if (instr_valid == 1'b0) chk(mem_req == 1'b0, "R7 idle req", mem_req, 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=0", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0; instr_valid = 1'b0;
    stk.delete(); exp_ovf = 0; exp_unf = 0; exp_rdy = 1;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk(tos == 16'h0 && ovf == 0 && unf == 0, "R1 outputs", {tos, 6'b0, ovf, unf}, 0);
    chk(instr_ready == 1'b1 && mem_req == 1'b0, "R1 handshake", {instr_ready, mem_req}, 2'b10);
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] addr);
    bit two_cyc, do_ld, do_st;
    int a, b, r;
    logic [15:0] ldval;
    @(negedge clk);
    instr_valid = 1'b1;
    instr = {op, 5'b10101, addr};  // pad bits nonzero, must be ignored (R2)
    #1;
    do_ld = (op == 3'd0) && stk.size() < 8;
    do_st = (op == 3'd1) && stk.size() > 0;
    two_cyc = do_ld || do_st;
    chk(mem_req == two_cyc, "R7 req", mem_req, two_cyc);
    if (do_ld)
      chk(mem_we == 0 && mem_addr == addr, "R3 read req", {mem_we, mem_addr}, {1'b0, addr});
    if (do_st)
      chk(mem_we == 1 && mem_addr == addr && mem_wdata == exp_tos(), "R4 write req",
          {mem_we, mem_addr, mem_wdata}, {1'b1, addr, exp_tos()});
    ldval = mem[addr];
    @(posedge clk); #1;
    instr_valid = 1'b0;
    if (two_cyc) begin
      exp_rdy = 0;
      @(posedge clk); #1;
      exp_rdy = 1;
      if (do_ld) stk.push_back(int'(ldval));
      else       void'(stk.pop_back());
    end else begin
      case (op)
        3'd0: exp_ovf = 1;
        3'd1: exp_unf = 1;
        3'd2, 3'd3, 3'd4: begin
          if (stk.size() < 2) exp_unf = 1;
          else begin
            b = stk.pop_back(); a = stk.pop_back();
            r = (op == 3'd2) ? a + b : (op == 3'd3) ? a - b : a * b;
            stk.push_back(int'(16'(r)));
          end
        end
        default: ;
      endcase
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 37 + 5);
    mem[8'h20] = 16'd3;  mem[8'h21] = 16'd5; mem[8'h22] = 16'd7; mem[8'h23] = 16'd2;
    mem[8'h40] = 16'd10; mem[8'h41] = 16'd3;
    mem[8'h42] = 16'hFFFF; mem[8'h43] = 16'h0002;
    mem[8'h44] = 16'h1234; mem[8'h45] = 16'h0100;
    mem_rdata = '0;

    do_reset();

    // R11 expression (X*Y)+(W*U) -> Z
    issue(0, 8'h20); issue(0, 8'h21); issue(4, 0);
    issue(0, 8'h22); issue(0, 8'h23); issue(4, 0);
    issue(2, 0); issue(1, 8'h30);
    @(negedge clk);
    chk(mem[8'h30] == 16'd29, "R11 stored", mem[8'h30], 29);
    chk(stk.size() == 0 && tos == 0, "R11 empty", tos, 0);
    issue(0, 8'h30);
    @(negedge clk);
    chk(tos == 16'd29, "R11 reload", tos, 29);
    issue(1, 8'h31);

    // R6 subtract order
    issue(0, 8'h40); issue(0, 8'h41); issue(3, 0);
    @(negedge clk);
    chk(tos == 16'd7, "R6 sub", tos, 7);
    issue(1, 8'h32);

    // R5 wrap and truncation
    issue(0, 8'h42); issue(0, 8'h43); issue(2, 0);
    @(negedge clk);
    chk(tos == 16'h0001, "R5 add wrap", tos, 1);
    issue(0, 8'h44); issue(0, 8'h45); issue(4, 0);
    @(negedge clk);
    chk(tos == 16'h3400, "R5 mul trunc", tos, 16'h3400);
    issue(2, 0);
    @(negedge clk);
    chk(tos == 16'h3401, "R5 depth fold", tos, 16'h3401);

    // R2 reserved opcodes: no effect
    issue(5, 8'h33); issue(6, 8'h34); issue(7, 8'h35);
    @(negedge clk);
    chk(tos == 16'h3401 && !ovf && !unf, "R2 reserved", tos, 16'h3401);
    issue(1, 8'h36);
    @(negedge clk);
    chk(mem[8'h36] == 16'h3401 && tos == 0, "R2 depth kept", mem[8'h36], 16'h3401);

    // R8 underflow
    issue(1, 8'h50);
    @(negedge clk);
    chk(unf == 1 && mem[8'h50] == 16'(8'h50 * 37 + 5), "R8 pop empty", unf, 1);
    issue(0, 8'h41); issue(3, 0);
    @(negedge clk);
    chk(tos == 16'd3 && unf == 1, "R8 arith one entry", tos, 3);
    repeat (3) @(negedge clk);
    chk(unf == 1, "R8 sticky", unf, 1);

    // R9 overflow
    do_reset();
    for (int i = 0; i < 8; i++) issue(0, 8'(8'h60 + i));
    issue(0, 8'h70);
    @(negedge clk);
    chk(ovf == 1 && tos == 16'((8'h67) * 37 + 5), "R9 full discard", tos, 16'((8'h67) * 37 + 5));
    issue(1, 8'h71);
    @(negedge clk);
    chk(mem[8'h71] == 16'((8'h67) * 37 + 5) && tos == 16'((8'h66) * 37 + 5), "R9 contents",
        tos, 16'((8'h66) * 37 + 5));
    chk(ovf == 1 && unf == 0, "R9 sticky", {ovf, unf}, 2'b10);
    for (int i = 0; i < 7; i++) issue(2, 0);
    issue(1, 8'h72);
    @(negedge clk);
    chk(tos == 0 && unf == 1, "R8 fold to one", unf, 1);

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule